// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator with Output Gating

This block turns a handful of already-digitized supply status flags into the reset and protection outputs that a processor subsystem needs. A main-supply brownout (supply under its reset threshold), the main supply falling beneath the backup battery, and a watchdog expiry strobe are merged into one processor reset. That reset asserts at once and is then stretched by a hold interval counted in timebase ticks after every cause has cleared.

Next to the stretched reset, the block provides an unstretched low-line flag that follows the threshold comparator. It also provides a chip-enable path that is blocked while the supply is low, so a memory cannot be written during a brownout. A power-fail warning output reports either the power-fail comparator or a supply below the battery. The hold length is chosen at build time: a short preset or a long preset counted on a millisecond tick, or a count of ticks from an external timebase input.

Top module: `rpg_reset_gen`

## Requirements
- R1: `rst_out_n` is 0 in every cycle in which `vcc_low` or `vcc_below_bat` is 1, with no clock latency.
- R2: Once both supply flags are 0, the reset stays asserted until HOLD timebase ticks have been sampled on rising clock edges. It is released right after the edge that samples the HOLD-th tick.
- R3: If a supply flag rises again before the hold interval has finished, the tick count restarts from zero and a full HOLD ticks are needed again.
- R4: A `wd_expire` pulse sampled while the reset is released asserts the reset from the next cycle, for a full hold interval of HOLD ticks.
- R5: A `wd_expire` pulse sampled while the reset is already asserted has no effect on the release time.
- R6: `rst_out` is always the inverse of `rst_out_n`.
- R7: `low_line_n` equals the inverse of `vcc_low` in the same cycle, with no stretching.
- R8: `ce_out_n` equals `ce_in_n` while `vcc_low` is 0, and is 1 (inactive) while `vcc_low` is 1.
- R9: `pf_warn_n` is 0 whenever `pf_low` or `vcc_below_bat` is 1, and 1 otherwise.
- R10: When `rst_n` is released, the reset is asserted and a full hold interval of HOLD ticks is pending.
- R11: HOLD is SHORT_TICKS of `ms_tick` (HOLD_SEL short), LONG_TICKS of `ms_tick` (HOLD_SEL long), or EXT_TICKS of `ext_tick` (HOLD_SEL external). The tick input that is not selected is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset of the block |
| vcc_low | input | 1 | Main supply is under the reset threshold |
| vcc_below_bat | input | 1 | Main supply is beneath the backup battery |
| wd_expire | input | 1 | One-cycle watchdog expiry strobe |
| ce_in_n | input | 1 | Active-low chip-enable request |
| pf_low | input | 1 | Power-fail comparator reports its input low |
| ms_tick | input | 1 | One-cycle millisecond tick |
| ext_tick | input | 1 | One-cycle tick from the external timebase |
| rst_out_n | output | 1 | Active-low processor reset |
| rst_out | output | 1 | Active-high processor reset |
| low_line_n | output | 1 | Unstretched active-low low-supply flag |
| ce_out_n | output | 1 | Gated active-low chip enable |
| pf_warn_n | output | 1 | Active-low power-fail warning |

## Verification
The bench builds two copies. The first copy uses the short preset, scaled to 6 ticks. This lets random supply dips, watchdog strobes and tick patterns both finish and interrupt hold intervals many times within a short run. The second copy uses the external timebase with 4 ticks. It is fed millisecond ticks that must be ignored and external ticks that must count, which covers the timebase selection and the exact release edge.

// File: rtl/rpg_pkg.sv
package rpg_pkg;

  typedef enum logic [1:0] {
    HOLD_SHORT = 2'd0,
    HOLD_LONG  = 2'd1,
    HOLD_EXT   = 2'd2
  } hold_sel_t;

  // Number of timebase ticks in one hold interval for a given selection.
  function automatic int unsigned hold_ticks(hold_sel_t sel, int unsigned short_t,
                                             int unsigned long_t, int unsigned ext_t);
    case (sel)
      HOLD_LONG: return long_t;
      HOLD_EXT:  return ext_t;
      default:   return short_t;
    endcase
  endfunction

  // Largest value the hold counter ever has to represent.
  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // True when the tick just sampled completes the interval.
  function automatic logic interval_done(int unsigned count_now, int unsigned hold);
    return (count_now + 1) >= hold;
  endfunction

endpackage

// File: rtl/rpg_hold_timer.sv
module rpg_hold_timer
  import rpg_pkg::*;
#(
  parameter hold_sel_t   HOLD_SEL    = HOLD_SHORT,
  parameter int unsigned SHORT_TICKS = 50,
  parameter int unsigned LONG_TICKS  = 200,
  parameter int unsigned EXT_TICKS   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_bad,
  input  logic wd_expire,
  input  logic ms_tick,
  input  logic ext_tick,
  output logic hold_active,
  output logic wd_start,
  output logic release_evt
);
  localparam int unsigned HOLD = hold_ticks(HOLD_SEL, SHORT_TICKS, LONG_TICKS, EXT_TICKS);
  localparam int unsigned MAXT = max3(SHORT_TICKS, LONG_TICKS, EXT_TICKS);
  localparam int unsigned CW   = $clog2(MAXT + 1);

  logic          tick;
  logic [CW-1:0] cnt_q;
  logic          act_q;

  // The unselected tick source is read but never counted.
  assign tick = (HOLD_SEL == HOLD_EXT) ? ext_tick : ms_tick;

  // Named internal events for the assertions.
  assign wd_start    = !act_q && !supply_bad && wd_expire;
  assign release_evt = act_q && !supply_bad && tick && interval_done(32'(cnt_q), HOLD);
  assign hold_active = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (supply_bad) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (release_evt) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (act_q) begin
      if (tick) cnt_q <= cnt_q + 1'b1;
    end else if (wd_start) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end
  end

  assert_dip_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    supply_bad |=> (act_q && cnt_q == '0));

  assert_wd_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wd_start |=> (act_q && cnt_q == '0));

  assert_no_extend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !supply_bad && !tick) |=> $stable(cnt_q));

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < HOLD);

endmodule

// File: rtl/rpg_out_gate.sv
module rpg_out_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_low,
  input  logic vcc_below_bat,
  input  logic hold_active,
  input  logic ce_in_n,
  input  logic pf_low,
  output logic supply_bad,
  output logic rst_out_n,
  output logic rst_out,
  output logic low_line_n,
  output logic ce_out_n,
  output logic pf_warn_n
);
  logic rst_req;

  assign supply_bad = vcc_low | vcc_below_bat;
  assign rst_req    = hold_active | supply_bad;
  assign rst_out_n  = ~rst_req;
  assign rst_out    = rst_req;
  assign low_line_n = ~vcc_low;
  assign ce_out_n   = vcc_low ? 1'b1 : ce_in_n;
  assign pf_warn_n  = ~(pf_low | vcc_below_bat);

  assert_ce_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_low |-> ce_out_n);

  assert_pf_forced_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_below_bat |-> !pf_warn_n);

  assert_lowline_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_low |-> !low_line_n);

endmodule

// File: rtl/rpg_reset_gen.sv
module rpg_reset_gen
  import rpg_pkg::*;
#(
  parameter hold_sel_t   HOLD_SEL    = HOLD_SHORT,
  parameter int unsigned SHORT_TICKS = 50,
  parameter int unsigned LONG_TICKS  = 200,
  parameter int unsigned EXT_TICKS   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_low,
  input  logic vcc_below_bat,
  input  logic wd_expire,
  input  logic ce_in_n,
  input  logic pf_low,
  input  logic ms_tick,
  input  logic ext_tick,
  output logic rst_out_n,
  output logic rst_out,
  output logic low_line_n,
  output logic ce_out_n,
  output logic pf_warn_n
);
  logic supply_bad;
  logic hold_active;
  logic wd_start;
  logic release_evt;

  rpg_hold_timer #(
    .HOLD_SEL   (HOLD_SEL),
    .SHORT_TICKS(SHORT_TICKS),
    .LONG_TICKS (LONG_TICKS),
    .EXT_TICKS  (EXT_TICKS)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_bad (supply_bad),
    .wd_expire  (wd_expire),
    .ms_tick    (ms_tick),
    .ext_tick   (ext_tick),
    .hold_active(hold_active),
    .wd_start   (wd_start),
    .release_evt(release_evt)
  );

  rpg_out_gate u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .vcc_low      (vcc_low),
    .vcc_below_bat(vcc_below_bat),
    .hold_active  (hold_active),
    .ce_in_n      (ce_in_n),
    .pf_low       (pf_low),
    .supply_bad   (supply_bad),
    .rst_out_n    (rst_out_n),
    .rst_out      (rst_out),
    .low_line_n   (low_line_n),
    .ce_out_n     (ce_out_n),
    .pf_warn_n    (pf_warn_n)
  );

  assert_supply_forces_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (vcc_low || vcc_below_bat) |-> !rst_out_n);

  assert_wd_reset_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wd_start |=> !rst_out_n);

  assert_release_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (release_evt && !wd_expire) |=> (rst_out_n || vcc_low || vcc_below_bat));

endmodule

// File: tb/tb_rpg_reset_gen.sv
`timescale 1ns/1ps
module tb_rpg_reset_gen;
  import rpg_pkg::*;

  localparam int HOLD_A = 6;
  localparam int HOLD_E = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_low = 0, vcc_below_bat = 0, wd_expire = 0, ce_in_n = 1, pf_low = 0;
  logic ms_tick = 0, ext_tick = 0;
  logic rst_out_n, rst_out, low_line_n, ce_out_n, pf_warn_n;
  logic e_rst_out_n, e_rst_out, e_low_line_n, e_ce_out_n, e_pf_warn_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rpg_reset_gen #(.HOLD_SEL(HOLD_SHORT), .SHORT_TICKS(HOLD_A), .LONG_TICKS(9), .EXT_TICKS(3)) dut (
    .clk(clk), .rst_n(rst_n), .vcc_low(vcc_low), .vcc_below_bat(vcc_below_bat),
    .wd_expire(wd_expire), .ce_in_n(ce_in_n), .pf_low(pf_low), .ms_tick(ms_tick),
    .ext_tick(ext_tick), .rst_out_n(rst_out_n), .rst_out(rst_out),
    .low_line_n(low_line_n), .ce_out_n(ce_out_n), .pf_warn_n(pf_warn_n));

  rpg_reset_gen #(.HOLD_SEL(HOLD_EXT), .SHORT_TICKS(HOLD_A), .LONG_TICKS(9), .EXT_TICKS(HOLD_E)) dut_ext (
    .clk(clk), .rst_n(rst_n), .vcc_low(vcc_low), .vcc_below_bat(vcc_below_bat),
    .wd_expire(wd_expire), .ce_in_n(ce_in_n), .pf_low(pf_low), .ms_tick(ms_tick),
    .ext_tick(ext_tick), .rst_out_n(e_rst_out_n), .rst_out(e_rst_out),
    .low_line_n(e_low_line_n), .ce_out_n(e_ce_out_n), .pf_warn_n(e_pf_warn_n));

  // Reference state for the short-preset copy, kept from the requirements.
  bit m_in_reset = 1;
  int m_ticks_seen = 0;

  always @(posedge clk) begin
    if (!rst_n || vcc_low || vcc_below_bat) begin
      m_in_reset   = 1;
      m_ticks_seen = 0;
    end else if (m_in_reset) begin
      if (ms_tick) m_ticks_seen++;
      if (m_ticks_seen >= HOLD_A) begin
        m_in_reset   = 0;
        m_ticks_seen = 0;
      end
    end else if (wd_expire) begin
      m_in_reset   = 1;
      m_ticks_seen = 0;
    end
  end

  function automatic bit exp_rst_n();
    return !(m_in_reset || vcc_low || vcc_below_bat);
  endfunction

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b expected=%b at %0t", req, got, exp, $time);
    end
  endtask

  // Full compare of the short-preset copy against the reference.
  task automatic compare_all();
    check(rst_out_n, exp_rst_n(), (vcc_low || vcc_below_bat) ? "R1" : "R2");
    check(rst_out, ~rst_out_n, "R6");
    check(low_line_n, ~vcc_low, "R7");
    check(ce_out_n, vcc_low ? 1'b1 : ce_in_n, "R8");
    check(pf_warn_n, ~(pf_low | vcc_below_bat), "R9");
  endtask

  // Drive inputs at a falling edge, pass one rising edge, compare at the next falling edge.
  task automatic step(input logic lo, input logic bat, input logic wd, input logic tk,
                      input logic etk);
    vcc_low = lo; vcc_below_bat = bat; wd_expire = wd; ms_tick = tk; ext_tick = etk;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    int unsigned seed;
    seed = 32'h5EED_0042;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check(rst_out_n, 1'b0, "R10");
    rst_n = 1'b1;
    @(negedge clk);
    check(rst_out_n, 1'b0, "R10");

    // R11: external copy ignores ms ticks and counts only ext ticks.
    for (int i = 0; i < HOLD_A - 1; i++) step(0, 0, 0, 1, 0);
    check(rst_out_n, 1'b0, "R10");
    step(0, 0, 0, 1, 0);
    check(rst_out_n, 1'b1, "R10");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0);
    check(e_rst_out_n, 1'b0, "R11");
    for (int i = 0; i < HOLD_E - 1; i++) step(0, 0, 0, 0, 1);
    check(e_rst_out_n, 1'b0, "R11");
    step(0, 0, 0, 0, 1);
    check(e_rst_out_n, 1'b1, "R11");

    // R4: watchdog pulse starts a full interval from the next cycle.
    step(0, 0, 1, 0, 0);
    check(rst_out_n, 1'b0, "R4");
    for (int i = 0; i < HOLD_A - 1; i++) step(0, 0, 0, 1, 0);
    check(rst_out_n, 1'b0, "R4");
    step(0, 0, 0, 1, 0);
    check(rst_out_n, 1'b1, "R4");

    // R5: watchdog pulse mid-interval does not delay release.
    step(0, 0, 1, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0);
    check(rst_out_n, 1'b0, "R5");
    step(0, 0, 0, 1, 0);
    check(rst_out_n, 1'b1, "R5");

    // R3: dip before the interval ends restarts the count.
    step(1, 0, 0, 0, 0);
    check(rst_out_n, 1'b0, "R1");
    check(low_line_n, 1'b0, "R7");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0);
    step(0, 1, 0, 1, 0);
    check(pf_warn_n, 1'b0, "R9");
    for (int i = 0; i < HOLD_A - 1; i++) step(0, 0, 0, 1, 0);
    check(rst_out_n, 1'b0, "R3");
    check(low_line_n, 1'b1, "R7");
    step(0, 0, 0, 1, 0);
    check(rst_out_n, 1'b1, "R3");

    // R8: chip enable passes when supply good, blocked when low.
    ce_in_n = 0;
    step(0, 0, 0, 0, 0);
    check(ce_out_n, 1'b0, "R8");
    step(1, 0, 0, 0, 0);
    check(ce_out_n, 1'b1, "R8");

    // Random phase.
    for (int i = 0; i < 3000; i++) begin
      ce_in_n = 1'($urandom_range(0, 1));
      pf_low  = ($urandom_range(0, 7) == 0);
      step(($urandom_range(0, 23) == 0), ($urandom_range(0, 39) == 0),
           ($urandom_range(0, 29) == 0), ($urandom_range(0, 2) == 0),
           1'($urandom_range(0, 1)));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog timeout R2 got=hang expected=finish");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule